// File: doc/BRIEF.md
# Command-Unlock Flash Program/Erase Sequencer

This block drives a byte-wide parallel flash device that accepts commands only after a fixed two-write unlock prelude. A client asks for one of two operations through a one-cycle request: a byte program, which carries a target address and a data byte, or a sector erase, which carries the sector address. The sequencer produces every command write on the flash bus. It waits a fixed settling gap after each write. It then polls the device until a toggling status bit stops moving, and finally sends the read-mode command so the array can be read normally again.

Completion is detected by reading the request address twice back to back and comparing the two bytes. Equal bytes mean the embedded algorithm has finished. If the number of unequal pairs reaches a configured limit, the sequencer gives up and still restores read mode. In that case it flags a timeout on the single-cycle done pulse. Verification of the array contents and the choice of flash bank belong to the surrounding logic.

Top module: `flash_cmd_seq`

## Requirements
- R1: After reset, busy, done, timeout_err, fl_we and fl_oe are all low.
- R2: A request (req_valid high while busy is low) is taken at that clock edge, and busy is high from the next cycle. req_erase=1 selects sector erase and req_erase=0 selects byte program.
- R3: A byte program issues four writes in this order: 0xAA to address 0x555, 0x55 to 0x2AA, 0xA0 to 0x555, then req_data to req_addr.
- R4: A sector erase issues six writes in this order: 0xAA to 0x555, 0x55 to 0x2AA, 0x80 to 0x555, 0xAA to 0x555, 0x55 to 0x2AA, then 0x30 to req_addr.
- R5: Every bus access takes STROBE_CYC+3 cycles: one launch cycle and one setup cycle with no strobe, then STROBE_CYC cycles of fl_we (write) or fl_oe (read), then one hold cycle. fl_addr and fl_wdata stay fixed through the strobe and the hold cycle, and fl_we and fl_oe are never high together.
- R6: After every write, the sequencer leaves GAP_CYC+1 cycles without bus activity before it launches the next access. GAP_CYC = ceil(CLK_MHZ*GAP_NS/1000), with a minimum of 1.
- R7: Once the last command write and its gap are done, the sequencer reads req_addr twice back to back per attempt. The read data is captured in the last strobe cycle. The operation is complete when the two bytes are equal, that is, when their XOR is zero.
- R8: After POLL_LIMIT unequal pairs, polling stops and the operation ends with a timeout. A pair that matches on attempt POLL_LIMIT itself is a success.
- R9: After completion or timeout, the sequencer writes 0xF0 to req_addr, followed by the R6 gap.
- R10: done is high for exactly one cycle right after that final gap, and busy is still high in that cycle. timeout_err is high only in that cycle, and only on a timeout. busy is low in the following cycle.
- R11: A request presented while busy is high, including the done cycle, is ignored: the bus sequence in progress is not altered and no new operation starts afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken when busy is low |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr | input | ADDR_W | Target byte address or sector address |
| req_data | input | 8 | Byte to program (ignored for erase) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| timeout_err | output | 1 | High with done when polling gave up |
| fl_addr | output | ADDR_W | Flash address |
| fl_wdata | output | 8 | Flash write data |
| fl_rdata | input | 8 | Flash read data |
| fl_we | output | 1 | Flash write strobe, active high |
| fl_oe | output | 1 | Flash read strobe, active high |

## Verification
Checks in the RTL run on every cycle and cover the shape of each access: strobe length, strobe exclusivity, and a stable address over the strobe and hold. They also cover the minimum quiet spacing after every write, the one-cycle done pulse, timeout_err appearing only with done, the poll counter staying inside its limit, and request fields being frozen while busy. The order and values of the command writes, the count of read pairs before a match, the boundary between a match on the last allowed pair and a timeout, and the absence of any restart after hammered requests are only visible in the scenarios. There, a toggling flash model and a per-cycle reference queue predict every output.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE, SQ_CMD, SQ_CGAP, SQ_RDA, SQ_RDB, SQ_RST, SQ_RGAP, SQ_DONE
    } sq_state_e;

    typedef enum logic [1:0] {
        BE_IDLE, BE_SETUP, BE_STROBE, BE_HOLD
    } be_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } sq_op_e;

    localparam logic [11:0] KEY_ADDR_HI   = 12'h555;
    localparam logic [11:0] KEY_ADDR_LO   = 12'h2AA;
    localparam logic [7:0]  CMD_KEY1      = 8'hAA;
    localparam logic [7:0]  CMD_KEY2      = 8'h55;
    localparam logic [7:0]  CMD_ERASE_ARM = 8'h80;
    localparam logic [7:0]  CMD_SECTOR_GO = 8'h30;
    localparam logic [7:0]  CMD_BYTE_PGM  = 8'hA0;
    localparam logic [7:0]  CMD_READ_MODE = 8'hF0;

    // One command write: either a fixed offset/code or the request's own address/data.
    typedef struct packed {
        logic        tgt_addr;
        logic        tgt_data;
        logic [11:0] offs;
        logic [7:0]  code;
    } sq_step_t;

    function automatic sq_step_t sq_step(sq_op_e op, logic [2:0] idx);
        sq_step_t s;
        s = '0;
        case (idx)
            3'd0: begin s.offs = KEY_ADDR_HI; s.code = CMD_KEY1; end
            3'd1: begin s.offs = KEY_ADDR_LO; s.code = CMD_KEY2; end
            3'd2: begin
                s.offs = KEY_ADDR_HI;
                s.code = (op == OP_ERASE) ? CMD_ERASE_ARM : CMD_BYTE_PGM;
            end
            3'd3: begin
                if (op == OP_ERASE) begin
                    s.offs = KEY_ADDR_HI; s.code = CMD_KEY1;
                end else begin
                    s.tgt_addr = 1'b1; s.tgt_data = 1'b1;
                end
            end
            3'd4: begin s.offs = KEY_ADDR_LO; s.code = CMD_KEY2; end
            default: begin s.tgt_addr = 1'b1; s.code = CMD_SECTOR_GO; end
        endcase
        return s;
    endfunction

    function automatic logic [2:0] sq_last_step(sq_op_e op);
        return (op == OP_ERASE) ? 3'd5 : 3'd3;
    endfunction

    function automatic int sq_gap_cycles(int mhz, int ns);
        int c;
        c = (mhz * ns + 999) / 1000;
        return (c < 1) ? 1 : c;
    endfunction

endpackage

// File: rtl/fsq_bus_engine.sv
module fsq_bus_engine
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int STB_CYC = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go,
    input  logic              go_rd,
    input  logic [ADDR_W-1:0] go_addr,
    input  logic [7:0]        go_wdata,
    output logic              ack,
    output logic [7:0]        rd_byte,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              fl_we,
    output logic              fl_oe
);
    localparam int SCW = (STB_CYC > 1) ? $clog2(STB_CYC) : 1;
    localparam logic [SCW-1:0] SC_LAST = SCW'(STB_CYC - 1);

    be_state_e         st_q;
    logic [SCW-1:0]    scnt_q;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        rbyte_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= BE_IDLE;
            scnt_q  <= '0;
            rd_q    <= 1'b0;
            addr_q  <= '0;
            data_q  <= '0;
            rbyte_q <= '0;
        end else begin
            case (st_q)
                BE_IDLE: begin
                    if (go) begin
                        addr_q <= go_addr;
                        data_q <= go_wdata;
                        rd_q   <= go_rd;
                        st_q   <= BE_SETUP;
                    end
                end
                BE_SETUP: begin
                    scnt_q <= '0;
                    st_q   <= BE_STROBE;
                end
                BE_STROBE: begin
                    if (scnt_q == SC_LAST) begin
                        st_q <= BE_HOLD;
                        if (rd_q) rbyte_q <= fl_rdata;
                    end else begin
                        scnt_q <= scnt_q + 1'b1;
                    end
                end
                default: st_q <= BE_IDLE;
            endcase
        end
    end

    assign fl_addr  = addr_q;
    assign fl_wdata = data_q;
    assign fl_we    = (st_q == BE_STROBE) && !rd_q;
    assign fl_oe    = (st_q == BE_STROBE) && rd_q;
    assign ack      = (st_q == BE_HOLD);
    assign rd_byte  = rbyte_q;

    // checker: length of the current strobe run
    logic [15:0] run_q;
    always_ff @(posedge clk) begin
        if (rst) run_q <= '0;
        else if (fl_we || fl_oe) run_q <= run_q + 1'b1;
        else run_q <= '0;
    end

    // R5
    strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(fl_we && fl_oe));
    // R5
    strobe_len_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(fl_we) || $fell(fl_oe)) |-> (run_q == 16'(STB_CYC)));
    // R5
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        ((fl_we || fl_oe) && run_q != 0) |-> ($stable(fl_addr) && $stable(fl_wdata)));
    // R5
    addr_after_chk: assert property (@(posedge clk) disable iff (rst)
        ($fell(fl_we) || $fell(fl_oe)) |-> ($stable(fl_addr) && $stable(fl_wdata)));

endmodule

// File: rtl/fsq_gap_timer.sv
module fsq_gap_timer #(
    parameter int GAP_CYC = 250
) (
    input  logic clk,
    input  logic rst,
    input  logic go,
    output logic fin
);
    localparam int CW = (GAP_CYC > 1) ? $clog2(GAP_CYC) : 1;

    logic [CW-1:0] cnt_q;
    logic          run_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            run_q <= 1'b0;
        end else if (go) begin
            cnt_q <= CW'(GAP_CYC - 1);
            run_q <= 1'b1;
        end else if (run_q) begin
            if (cnt_q == '0) run_q <= 1'b0;
            else cnt_q <= cnt_q - 1'b1;
        end
    end

    assign fin = run_q && (cnt_q == '0);

    // R6
    gap_restart_chk: assert property (@(posedge clk) disable iff (rst)
        go |-> !run_q);

endmodule

// File: rtl/fsq_poll_judge.sv
module fsq_poll_judge #(
    parameter int LIMIT = 1000000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear,
    input  logic       pair_valid,
    input  logic [7:0] first_b,
    input  logic [7:0] second_b,
    output logic       settle,
    output logic       expire
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] tries_q;

    assign settle = ((first_b ^ second_b) == 8'h00);
    assign expire = pair_valid && !settle && (tries_q == LAST);

    always_ff @(posedge clk) begin
        if (rst || clear) tries_q <= '0;
        else if (pair_valid && !settle && !expire) tries_q <= tries_q + 1'b1;
    end

    // R8
    tries_range_chk: assert property (@(posedge clk) disable iff (rst)
        32'(tries_q) < LIMIT);
    // R8
    tries_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!clear && !pair_valid) |=> $stable(tries_q));

endmodule

// File: rtl/flash_cmd_seq.sv
module flash_cmd_seq
    import flash_seq_pkg::*;
#(
    parameter int ADDR_W     = 13,
    parameter int STROBE_CYC = 2,
    parameter int CLK_MHZ    = 250,
    parameter int GAP_NS     = 1000,
    parameter int POLL_LIMIT = 1000000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_erase,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [7:0]        req_data,
    output logic              busy,
    output logic              done,
    output logic              timeout_err,
    output logic [ADDR_W-1:0] fl_addr,
    output logic [7:0]        fl_wdata,
    input  logic [7:0]        fl_rdata,
    output logic              fl_we,
    output logic              fl_oe
);
    localparam int GAP_CYC = sq_gap_cycles(CLK_MHZ, GAP_NS);
    localparam int MIN_QUIET = GAP_CYC + 4;

    sq_state_e         state_q;
    logic              launched_q;
    logic [2:0]        step_q;
    sq_op_e            op_q;
    logic [ADDR_W-1:0] addr_q;
    logic [7:0]        data_q;
    logic [7:0]        rda_q;
    logic              tmo_q;

    sq_step_t          cur_step;
    logic              bus_go, bus_rd, bus_ack, gap_go, gap_fin;
    logic [ADDR_W-1:0] bus_addr;
    logic [7:0]        bus_wdata, bus_rbyte;
    logic              accept, pair_valid, settle, expire;

    assign accept   = (state_q == SQ_IDLE) && req_valid;
    assign cur_step = sq_step(op_q, step_q);

    always_comb begin
        bus_rd    = 1'b0;
        bus_addr  = addr_q;
        bus_wdata = 8'h00;
        case (state_q)
            SQ_CMD: begin
                bus_addr  = cur_step.tgt_addr ? addr_q : ADDR_W'(cur_step.offs);
                bus_wdata = cur_step.tgt_data ? data_q : cur_step.code;
            end
            SQ_RDA, SQ_RDB: bus_rd = 1'b1;
            SQ_RST: bus_wdata = CMD_READ_MODE;
            default: ;
        endcase
    end

    assign bus_go = !launched_q && (state_q == SQ_CMD || state_q == SQ_RDA ||
                                    state_q == SQ_RDB || state_q == SQ_RST);
    assign gap_go = !launched_q && (state_q == SQ_CGAP || state_q == SQ_RGAP);
    assign pair_valid = (state_q == SQ_RDB) && bus_ack;

    fsq_bus_engine #(.ADDR_W(ADDR_W), .STB_CYC(STROBE_CYC)) bus_i (
        .clk(clk), .rst(rst), .go(bus_go), .go_rd(bus_rd),
        .go_addr(bus_addr), .go_wdata(bus_wdata),
        .ack(bus_ack), .rd_byte(bus_rbyte),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .fl_rdata(fl_rdata),
        .fl_we(fl_we), .fl_oe(fl_oe)
    );

    fsq_gap_timer #(.GAP_CYC(GAP_CYC)) gap_i (
        .clk(clk), .rst(rst), .go(gap_go), .fin(gap_fin)
    );

    fsq_poll_judge #(.LIMIT(POLL_LIMIT)) judge_i (
        .clk(clk), .rst(rst), .clear(accept), .pair_valid(pair_valid),
        .first_b(rda_q), .second_b(bus_rbyte),
        .settle(settle), .expire(expire)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q    <= SQ_IDLE;
            launched_q <= 1'b0;
            step_q     <= '0;
            op_q       <= OP_PROGRAM;
            addr_q     <= '0;
            data_q     <= '0;
            rda_q      <= '0;
            tmo_q      <= 1'b0;
        end else begin
            if (bus_go || gap_go) launched_q <= 1'b1;
            case (state_q)
                SQ_IDLE: begin
                    if (req_valid) begin
                        op_q    <= sq_op_e'(req_erase);
                        addr_q  <= req_addr;
                        data_q  <= req_data;
                        step_q  <= '0;
                        tmo_q   <= 1'b0;
                        state_q <= SQ_CMD;
                    end
                end
                SQ_CMD: if (bus_ack) begin
                    launched_q <= 1'b0;
                    state_q    <= SQ_CGAP;
                end
                SQ_CGAP: if (gap_fin) begin
                    launched_q <= 1'b0;
                    if (step_q == sq_last_step(op_q)) begin
                        state_q <= SQ_RDA;
                    end else begin
                        step_q  <= step_q + 1'b1;
                        state_q <= SQ_CMD;
                    end
                end
                SQ_RDA: if (bus_ack) begin
                    launched_q <= 1'b0;
                    rda_q      <= bus_rbyte;
                    state_q    <= SQ_RDB;
                end
                SQ_RDB: if (bus_ack) begin
                    launched_q <= 1'b0;
                    if (settle) begin
                        tmo_q   <= 1'b0;
                        state_q <= SQ_RST;
                    end else if (expire) begin
                        tmo_q   <= 1'b1;
                        state_q <= SQ_RST;
                    end else begin
                        state_q <= SQ_RDA;
                    end
                end
                SQ_RST: if (bus_ack) begin
                    launched_q <= 1'b0;
                    state_q    <= SQ_RGAP;
                end
                SQ_RGAP: if (gap_fin) begin
                    launched_q <= 1'b0;
                    state_q    <= SQ_DONE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign busy        = (state_q != SQ_IDLE);
    assign done        = (state_q == SQ_DONE);
    assign timeout_err = done && tmo_q;

    // checker: quiet cycles since the last strobe and whether it was a write
    logic [15:0] quiet_q;
    logic        after_wr_q;
    always_ff @(posedge clk) begin
        if (rst) begin
            quiet_q    <= '0;
            after_wr_q <= 1'b0;
        end else begin
            if (fl_we || fl_oe) quiet_q <= '0;
            else if (quiet_q != 16'hFFFF) quiet_q <= quiet_q + 1'b1;
            if (fl_we) after_wr_q <= 1'b1;
            else if (fl_oe) after_wr_q <= 1'b0;
        end
    end

    // R6
    write_gap_chk: assert property (@(posedge clk) disable iff (rst)
        ((fl_we || fl_oe) && quiet_q != 0 && after_wr_q) |-> (32'(quiet_q) >= MIN_QUIET));
    // R2
    accept_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && req_valid) |=> busy);
    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));
    // R10
    done_busy_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> busy);
    // R8
    tmo_with_done_chk: assert property (@(posedge clk) disable iff (rst)
        timeout_err |-> done);
    // R11
    busy_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> ($stable(addr_q) && $stable(op_q) && $stable(data_q)));
    // R5
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!fl_we && !fl_oe));

endmodule

// File: tb/flash_cmd_seq_tb_top.sv
module flash_cmd_seq_tb_top;
    localparam int AW  = 13;
    localparam int STB = 2;
    localparam int MHZ = 250;
    localparam int GNS = 20;
    localparam int LIM = 5;
    localparam int GAP = ((MHZ * GNS + 999) / 1000 < 1) ? 1 : (MHZ * GNS + 999) / 1000;
    localparam int WATCHDOG = 150000;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic          req_erase = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [7:0]    req_data = '0;
    logic          busy, done, timeout_err, fl_we, fl_oe;
    logic [AW-1:0] fl_addr;
    logic [7:0]    fl_wdata;
    logic [7:0]    fl_rdata;

    always #2 clk = ~clk;

    flash_cmd_seq #(.ADDR_W(AW), .STROBE_CYC(STB), .CLK_MHZ(MHZ),
                    .GAP_NS(GNS), .POLL_LIMIT(LIM)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_erase(req_erase),
        .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
        .timeout_err(timeout_err), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .fl_we(fl_we), .fl_oe(fl_oe)
    );

    // ---------------- flash model: status bit 6 toggles on each read while pending
    logic [7:0] fl_val = 8'h3C;
    logic       oe_prev = 1'b0;
    int         toggles_left = 0;
    int         tog_req = 0;
    int         tog_gen = 0;
    int         tog_seen = 0;
    assign fl_rdata = fl_val;

    always @(negedge clk) begin
        if (tog_gen != tog_seen) begin
            toggles_left = tog_req;
            tog_seen = tog_gen;
        end
        if (fl_oe && !oe_prev && toggles_left > 0) begin
            fl_val = fl_val ^ 8'h40;
            toggles_left = toggles_left - 1;
        end
        oe_prev = fl_oe;
    end

    // ---------------- reference model: one record per expected cycle
    typedef struct {
        bit    we, oe, busy, done, err;
        int    addr, wdata;
        string tag;
    } rec_t;
    rec_t  q[$];
    string idle_tag = "R1";
    int    n_cmp = 0;
    int    n_bad = 0;
    bit    run_cmp = 1'b0;
    bit    finished = 1'b0;
    int    cyc = 0;

    task automatic push(bit we, bit oe, bit b, bit d, bit e, int a, int w, string t);
        rec_t r;
        r.we = we; r.oe = oe; r.busy = b; r.done = d; r.err = e;
        r.addr = a; r.wdata = w; r.tag = t;
        q.push_back(r);
    endtask

    // R5: launch, setup, STB strobe cycles, hold
    task automatic m_bus(bit wr, int a, int w, string t);
        push(0, 0, 1, 0, 0, 0, 0, "R5");
        push(0, 0, 1, 0, 0, 0, 0, "R5");
        for (int i = 0; i < STB; i++) push(wr, !wr, 1, 0, 0, a, w, t);
        push(0, 0, 1, 0, 0, 0, 0, "R5");
    endtask

    // R6: quiet cycles after each write
    task automatic m_gap();
        for (int i = 0; i < GAP + 1; i++) push(0, 0, 1, 0, 0, 0, 0, "R6");
    endtask

    task automatic m_op(bit erase, int a, int d, int t);
        int  wa[6];
        int  wd[6];
        int  nw;
        int  np;
        bit  tmo;
        int  k;
        rec_t r;
        if (erase) begin   // R4
            wa = '{'h555, 'h2AA, 'h555, 'h555, 'h2AA, a};
            wd = '{'hAA, 'h55, 'h80, 'hAA, 'h55, 'h30};
            nw = 6;
        end else begin     // R3
            wa = '{'h555, 'h2AA, 'h555, a, 0, 0};
            wd = '{'hAA, 'h55, 'hA0, d, 0, 0};
            nw = 4;
        end
        push(0, 0, 0, 0, 0, 0, 0, "R2");
        k = q.size();
        for (int i = 0; i < nw; i++) begin
            m_bus(1, wa[i], wd[i], erase ? "R4" : "R3");
            m_gap();
        end
        r = q[k]; r.tag = "R2"; q[k] = r;
        // R7 / R8: pair i matches once the second read saw no toggle
        tmo = 1; np = LIM;
        for (int i = 0; i < LIM; i++) begin
            if (t <= 2 * i + 1) begin np = i + 1; tmo = 0; break; end
        end
        for (int i = 0; i < np; i++) begin
            m_bus(0, a, 0, "R7");
            m_bus(0, a, 0, "R7");
        end
        m_bus(1, a, 'hF0, "R9");   // R9
        m_gap();
        push(0, 0, 1, 1, tmo, 0, 0, tmo ? "R8" : "R10");   // R10
    endtask

    always @(negedge clk) begin
        if (run_cmp) begin
            rec_t e;
            bit   bad;
            if (q.size() > 0) e = q.pop_front();
            else begin
                e.we = 0; e.oe = 0; e.busy = 0; e.done = 0; e.err = 0;
                e.addr = 0; e.wdata = 0; e.tag = idle_tag;
            end
            bad = (fl_we != e.we) || (fl_oe != e.oe) || (busy != e.busy) ||
                  (done != e.done) || (timeout_err != e.err) ||
                  (e.we && (int'(fl_addr) != e.addr || int'(fl_wdata) != e.wdata)) ||
                  (e.oe && int'(fl_addr) != e.addr);
            n_cmp++;
            if (bad) begin
                n_bad++;
                $display("FAIL %s cyc=%0d actual we=%0b oe=%0b busy=%0b done=%0b err=%0b addr=%h wd=%h expected we=%0b oe=%0b busy=%0b done=%0b err=%0b addr=%h wd=%h",
                         e.tag, cyc, fl_we, fl_oe, busy, done, timeout_err, fl_addr, fl_wdata,
                         e.we, e.oe, e.busy, e.done, e.err, e.addr, e.wdata);
            end
        end
    end

    always @(posedge clk) cyc <= cyc + 1;

    task automatic do_req(bit erase, int a, int d, int t, bit hammer);
        while (q.size() > 0 || busy) begin @(posedge clk); #1; end
        tog_req = t;
        tog_gen = tog_gen + 1;
        m_op(erase, a, d, t);
        req_valid = 1; req_erase = erase; req_addr = AW'(a); req_data = 8'(d);
        @(posedge clk); #1;
        if (hammer) begin
            // R11: requests during busy and during the done cycle
            req_erase = !erase; req_addr = AW'(13'h0AB); req_data = 8'h11;
            do begin
                req_valid = (q.size() > 0);
                @(posedge clk); #1;
            end while (q.size() > 0);
            req_valid = 0;
        end else begin
            req_valid = 0;
            while (q.size() > 0) begin @(posedge clk); #1; end
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        #1;
        rst = 0;
        run_cmp = 1;                                 // R1 idle after reset
        repeat (5) @(posedge clk);
        #1;
        idle_tag = "R2";
        do_req(0, 'h123, 'h5C, 0, 0);                // R3 program, match at first pair
        do_req(0, 'h1FFF, 'hFF, 4, 0);               // R3 program, three pairs
        do_req(1, 'h1000, 0, 3, 0);                  // R4 erase, two pairs
        do_req(1, 'h0800, 0, 9, 0);                  // R8 match on the last allowed pair
        do_req(0, 'h0042, 'hA5, 10, 0);              // R8 timeout
        idle_tag = "R11";
        do_req(1, 'h0400, 0, 2, 1);                  // R11 hammered requests
        repeat (10) @(posedge clk);
        #1;
        do_req(0, 'h0555, 'h00, 1, 1);               // R11 second pass, R7 single toggle
        repeat (10) @(posedge clk);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        forever begin
            @(posedge clk);
            if (cyc > WATCHDOG && !finished) begin
                n_bad++;
                $display("FAIL watchdog R10 actual busy=%0b expected completion", busy);
                $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
                $finish;
            end
        end
    end

endmodule